// File: doc/BRIEF.md
# Synchronous Byte-Write Memory Core with Selectable Output Latency

This block is the storage and data-output stage of a synchronous single-port memory. Every access arrives already registered by an upstream burst sequencer as a select, an address, write data and the write controls. On each rising clock edge the core either writes any chosen subset of its four byte lanes or launches a read. Read data leaves through one of two paths, picked by a static mode input: a flow-through path that presents data in the cycle after the access is captured, or a pipelined path that adds an output register and presents it one cycle later. Deselects and writes stop the output after a single stage (single-cycle deselect). An asynchronous output enable gates the drive-enable signal that stands in for the pad drivers.

A power state machine lets a sleep input park the core. It has three states. PW_ACTIVE accepts accesses. PW_SLEEP ignores every access and keeps the array contents. PW_WAKE waits out a programmable recovery count. The transitions are:
- sleep sampled high in PW_ACTIVE goes to PW_SLEEP.
- sleep sampled low in PW_SLEEP goes to PW_WAKE and loads the counter.
- in PW_WAKE, sleep sampled high goes back to PW_SLEEP.
- in PW_WAKE, an expired counter goes to PW_ACTIVE.
- in PW_WAKE, otherwise the counter decrements.

Top module: `sram_dp_core`

## Requirements
- R1: When `gw_n` is 0 at an accepted edge, all four lanes are written, whatever `bw_n` and `lane_sel_n` hold. Lane k is `wdata[9k+8:9k]` and is selected by `lane_sel_n[k]`.
- R2: When `gw_n` is 1 and `bw_n` is 0, exactly the lanes whose `lane_sel_n` bit is 0 are written and the other lanes keep their contents. If no bit is 0, the access is a read.
- R3: When `gw_n` and `bw_n` are both 1, the access is a read and the array is unchanged.
- R4: With `pipe_mode` 0, a read accepted at edge E raises `rvalid` and shows the addressed word on `rdata` from just after E until the next edge.
- R5: With `pipe_mode` 1, a read accepted at edge E shows its word with `rvalid` high from just after edge E+1 until the next edge. Back-to-back reads stream one word per cycle.
- R6: Writes and deselects produce no valid output. After the last read, `rvalid` drops exactly one stage after that read's data, with no extra hold cycle.
- R7: `drive_en` is high only while `rvalid` is high and `oe_n` is 0. A change of `oe_n` takes effect without waiting for a clock edge.
- R8: When `sleep` is sampled high, that access and every access while asleep are ignored: nothing is written and `rvalid` and `drive_en` stay 0. The array contents are retained.
- R9: After `sleep` is sampled low at edge K, accesses at edges K through K+WAKE_CYC are ignored. The access at edge K+WAKE_CYC+1 is the first one accepted.
- R10: During reset, `rvalid`, `drive_en` and `rdata` are 0.
- R11: `rdata` is all zeros whenever `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access request this cycle (0 = deselect) |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, lane k at bits 9k+8:9k |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte-write master enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pipe_mode | input | 1 | 1 = registered output, 0 = flow-through |
| sleep | input | 1 | Low-power request, sampled at the clock edge |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data is valid this cycle |
| drive_en | output | 1 | Output driver enable (models high-Z control) |

## Verification
The latency properties assume `pipe_mode` only changes while no read is in flight, and that `sleep` is a clean synchronous level. The stimulus changes the mode only after idle cycles and drives every input at the falling edge. The bench covers all 64 combinations of the global-write, byte-write and lane-select inputs against an arithmetic model of the array, and reads back each result in flow-through mode. It streams reads in both output modes. It toggles `oe_n` between edges, and issues accesses on every edge through sleep and recovery so that the first accepted edge is pinned exactly.

// File: rtl/sram_dp_pkg.sv
package sram_dp_pkg;
    typedef enum logic [1:0] {
        PW_ACTIVE = 2'd0,
        PW_SLEEP  = 2'd1,
        PW_WAKE   = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_we,
    output logic             is_wr
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // global write overrides everything; otherwise the master enable gates each lane
        assign lane_we[k] = !gw_n || (!bw_n && !lane_sel_n[k]);
    end
    assign is_wr = |lane_we;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we[k]) mem[waddr] <= wdata[k*LANE_W +: LANE_W];
        end
        assign rdata[k*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/sram_pwr_fsm.sv
module sram_pwr_fsm
    import sram_dp_pkg::*;
#(
    parameter int WAKE_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep,
    output logic       awake,
    output pwr_state_t state
);
    localparam int CW = $clog2(WAKE_CYC + 1);

    pwr_state_t     nxt;
    logic [CW-1:0]  cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PW_ACTIVE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            PW_ACTIVE: if (sleep) nxt = PW_SLEEP;
            PW_SLEEP: begin
                if (!sleep) begin
                    nxt     = PW_WAKE;
                    cnt_nxt = CW'(WAKE_CYC - 1);
                end
            end
            PW_WAKE: begin
                if (sleep)            nxt = PW_SLEEP;
                else if (cnt == '0)   nxt = PW_ACTIVE;
                else                  cnt_nxt = cnt - 1'b1;
            end
            default: nxt = PW_ACTIVE;
        endcase
    end

    always_comb begin
        awake = (state == PW_ACTIVE);
    end
endmodule

// File: rtl/sram_dp_core.sv
module sram_dp_core
    import sram_dp_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int LANES    = 4,
    parameter int LANE_W   = 9,
    parameter int WAKE_CYC = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    gw_n,
    input  logic                    bw_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    oe_n,
    input  logic                    pipe_mode,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid,
    output logic                    drive_en
);
    localparam int DW = LANES * LANE_W;

    pwr_state_t        pstate;
    logic              awake, accept, is_wr, rd_acc;
    logic [LANES-1:0]  lane_we, lane_we_eff;
    logic              rd_s1, rd_s2;
    logic [ADDR_W-1:0] addr_s1;
    logic [DW-1:0]     arr_q, dout_q;

    sram_pwr_fsm #(.WAKE_CYC(WAKE_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .awake(awake), .state(pstate)
    );

    sram_wr_decode #(.LANES(LANES)) u_dec (
        .gw_n(gw_n), .bw_n(bw_n), .lane_sel_n(lane_sel_n),
        .lane_we(lane_we), .is_wr(is_wr)
    );

    assign accept      = sel && awake && !sleep;
    assign lane_we_eff = lane_we & {LANES{accept}};
    assign rd_acc      = accept && !is_wr;

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .we(lane_we_eff), .waddr(addr), .wdata(wdata),
        .raddr(addr_s1), .rdata(arr_q)
    );

    // capture stage and optional output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_s1   <= 1'b0;
            rd_s2   <= 1'b0;
            addr_s1 <= '0;
            dout_q  <= '0;
        end else begin
            rd_s1   <= rd_acc;
            addr_s1 <= addr;
            rd_s2   <= rd_s1 && awake && !sleep;
            dout_q  <= arr_q;
        end
    end

    always_comb begin
        rvalid   = awake && (pipe_mode ? rd_s2 : rd_s1);
        rdata    = rvalid ? (pipe_mode ? dout_q : arr_q) : '0;
        drive_en = rvalid && !oe_n;
    end
endmodule

// File: rtl/sram_dp_checks.sv
module sram_dp_checks
    import sram_dp_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             gw_n,
    input logic             sleep,
    input logic             oe_n,
    input logic             pipe_mode,
    input logic             awake,
    input logic             rd_acc,
    input logic [LANES-1:0] lane_we_eff,
    input pwr_state_t       pstate,
    input logic             rvalid,
    input logic             drive_en
);
    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_n && sel && awake && !sleep) |-> (&lane_we_eff)); // R1

    AST_FLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && rd_acc) |=> rvalid); // R4

    AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(rd_acc) && !sleep) |=> rvalid); // R5

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && (|lane_we_eff)) |=> !rvalid); // R6

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive_en); // R7

    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PW_SLEEP) |-> (!rvalid && !drive_en)); // R8

    AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (lane_we_eff == '0)); // R8

    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PW_WAKE) |-> (lane_we_eff == '0 && !rd_acc)); // R9
endmodule

bind sram_dp_core sram_dp_checks #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .gw_n(gw_n), .sleep(sleep),
    .oe_n(oe_n), .pipe_mode(pipe_mode), .awake(awake), .rd_acc(rd_acc),
    .lane_we_eff(lane_we_eff), .pstate(pstate), .rvalid(rvalid),
    .drive_en(drive_en)
);

// File: tb/sram_dp_core_bench.sv
`timescale 1ns/1ps
module sram_dp_core_bench;
    localparam int AW = 4;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int WK = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          gw_n = 1'b1, bw_n = 1'b1;
    logic [NL-1:0] lane_sel_n = '1;
    logic          oe_n = 1'b0, pipe_mode = 1'b0, sleep = 1'b0;
    logic [DW-1:0] rdata;
    logic          rvalid, drive_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [DW-1:0] model [DEPTH];

    always #2 clk = ~clk;

    sram_dp_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .WAKE_CYC(WK)) u_sram_dp_core (
        .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wdata(wdata),
        .gw_n(gw_n), .bw_n(bw_n), .lane_sel_n(lane_sel_n), .oe_n(oe_n),
        .pipe_mode(pipe_mode), .sleep(sleep), .rdata(rdata), .rvalid(rvalid),
        .drive_en(drive_en)
    );

    function automatic logic [DW-1:0] pat(int a, int salt);
        logic [DW-1:0] r;
        for (int k = 0; k < NL; k++) r[k*LW +: LW] = LW'(a * 37 + k * 11 + salt * 53 + 5);
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(logic s, int a, logic [DW-1:0] d, logic g, logic b, logic [NL-1:0] ls);
        sel = s; addr = AW'(a); wdata = d; gw_n = g; bw_n = b; lane_sel_n = ls;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R10: outputs quiet during reset even with a read presented
        put(1, 0, '0, 1, 1, '1);
        @(negedge clk); @(negedge clk);
        check("R10 rvalid", 64'(rvalid), 0);
        check("R10 drive_en", 64'(drive_en), 0);
        check("R10 rdata", 64'(rdata), 0);
        rst_n = 1'b1;
        put(0, 0, '0, 1, 1, '1);
        step();

        // fill array with global writes (R1 path)
        for (int a = 0; a < DEPTH; a++) begin
            put(1, a, pat(a, 0), 0, 1, '1);
            model[a] = pat(a, 0);
            step();
        end
        put(0, 0, '0, 1, 1, '1);
        step();

        // exhaustive write-control sweep in flow-through mode
        for (int c = 0; c < 64; c++) begin
            logic g = c[5];
            logic b = c[4];
            logic [NL-1:0] ls = NL'(c);
            logic [NL-1:0] m;
            int a = c % DEPTH;
            string tg;
            m = !g ? '1 : (!b ? ~ls : '0);
            tg = !g ? "R1" : (!b ? "R2" : "R3");
            put(1, a, pat(c, 1), g, b, ls);
            step();
            check({tg, " R4 R6 rvalid"}, 64'(rvalid), 64'(m == 0));
            check({tg, " R7 drive_en"}, 64'(drive_en), 64'(m == 0));
            if (m == 0) check({tg, " R4 rdata"}, 64'(rdata), 64'(model[a]));
            else        check({tg, " R11 rdata"}, 64'(rdata), 0);
            for (int k = 0; k < NL; k++)
                if (m[k]) model[a][k*LW +: LW] = pat(c, 1) >> (k * LW);
            put(1, a, '0, 1, 1, '1);
            step();
            check({tg, " readback"}, 64'(rdata), 64'(model[a]));
            put(0, 0, '0, 1, 1, '1);
            step();
            check("R6 deselect", 64'(rvalid), 0);
        end

        // R4 streaming flow-through reads, then deselect
        for (int k = 0; k <= 16; k++) begin
            if (k < 16) put(1, k, '0, 1, 1, '1);
            else        put(0, 0, '0, 1, 1, '1);
            step();
            check("R4 stream valid", 64'(rvalid), 64'(k < 16));
            if (k < 16) check("R4 stream data", 64'(rdata), 64'(model[k]));
        end

        // R5 pipelined streaming, R6 single-stage turn-off
        pipe_mode = 1'b1;
        step();
        for (int k = 0; k <= 17; k++) begin
            if (k < 16) put(1, k, '0, 1, 1, '1);
            else        put(0, 0, '0, 1, 1, '1);
            step();
            check("R5 R6 pipe valid", 64'(rvalid), 64'(k >= 1 && k <= 16));
            if (k >= 1 && k <= 16) check("R5 pipe data", 64'(rdata), 64'(model[k-1]));
            else                   check("R11 pipe idle", 64'(rdata), 0);
        end
        pipe_mode = 1'b0;
        step();

        // R7 asynchronous output enable inside a valid cycle
        put(1, 5, '0, 1, 1, '1);
        step();
        put(0, 0, '0, 1, 1, '1);
        check("R7 on", 64'(drive_en), 1);
        #0.5 oe_n = 1'b1;
        #0.5 check("R7 off async", 64'(drive_en), 0);
        check("R7 data still valid", 64'(rvalid), 1);
        #0.5 oe_n = 1'b0;
        #0.5 check("R7 back on", 64'(drive_en), 1);
        step();

        // R8 sleep ignores a write and reads; R9 recovery count
        sleep = 1'b1;
        put(1, 3, pat(3, 9), 0, 1, '1);
        step();
        check("R8 sleep edge", 64'(rvalid), 0);
        put(1, 3, '0, 1, 1, '1);
        for (int j = 0; j < 3; j++) begin
            step();
            check("R8 asleep valid", 64'(rvalid), 0);
            check("R8 asleep drive", 64'(drive_en), 0);
        end
        sleep = 1'b0;
        for (int j = 0; j <= WK + 1; j++) begin
            step();
            check("R9 wake valid", 64'(rvalid), 64'(j == WK + 1));
        end
        check("R8 R9 retained", 64'(rdata), 64'(model[3]));
        put(0, 0, '0, 1, 1, '1);
        step();
        finish_run();
    end
endmodule